// File: doc/BRIEF.md
# Two-Table Configurable Logic Cell

This block is one logic cell of a programmable array. It has five logic inputs and two 16-entry lookup tables. It also has two edge-triggered registers whose outputs can feed back into the table addresses without leaving the cell. A mode field sets how the two tables combine:

- **Split mode** gives two separate four-input functions.
- **Join mode** gives one five-input function.
- **Mux mode** lets the fifth logic input choose between two four-input functions. Each of those functions draws its variables on its own terms.

Because the register outputs can stand in for logic inputs, one cell can cover some functions that draw on seven variables.

The two registers share one clock, one clock enable and a single asynchronous clear. That clear is driven by two reset inputs, a direct one and a global one. Each register loads from the data input or from either table result. Each cell output shows a table result or a register value. All configuration arrives as plain parallel inputs held static by the surrounding fabric. The registers have no preset. A preset is obtained by storing the inverted value and using the clear.

Top module: `lc_cell`

## Requirements
- R1: In split mode each table is read at its own 4-bit address. Address bit 0 is `lin[0]`. Bit 1 is the variable named by pick bits [1:0]. Bit 2 is the variable named by pick bits [3:2]. Bit 3 is `lin[3]` when pick bit 4 is 0 and `lin[4]` when it is 1. The F result comes from `cfg_lut_f`, and the G result from `cfg_lut_g` using `cfg_pick_g`.
- R2: In join mode both the F and G results equal entry `addr` of `cfg_lut_g` when `lin[4]`=1, and of `cfg_lut_f` otherwise. `addr` is built from `cfg_pick_f` as in R1, except that bit 3 is always `lin[3]`. `cfg_pick_g` has no effect.
- R3: In mux mode each table forms its address from its own pick field as in R1, with bit 3 always `lin[3]`. Both results then equal the G table read when `lin[4]`=1 and the F table read otherwise.
- R4: A 2-bit variable select picks `lin[1]` for 0, `lin[2]` for 1, register X for 2 and register Y for 3.
- R5: `cfg_mode` encodes split as 0, join as 1 and mux as 2. Code 3 behaves exactly as split.
- R6: On a rising clock edge with `ce`=1, each register loads the value named by its 2-bit data select: 0 for `din`, 1 for the F result, 2 for the G result, 3 for `din`.
- R7: With `ce`=0 a clock edge leaves both registers unchanged.
- R8: Either `rst_dir` or `rst_glb` at 1 clears both registers at once, without a clock edge, and holds them at 0 whatever `ce` is.
- R9: Each output select of 2 bits shows the F result for 0, the G result for 1, register X for 2 and register Y for 3.
- R10: The table results reach the outputs with no register in the path. A change on `lin` shows on the outputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| ce | input | 1 | Clock enable for both registers |
| rst_dir | input | 1 | Direct asynchronous clear, active high |
| rst_glb | input | 1 | Global asynchronous clear, active high |
| lin | input | 5 | Logic inputs, bit 0 common address bit |
| din | input | 1 | Register data input |
| cfg_mode | input | 2 | Table combining mode |
| cfg_lut_f | input | 16 | F table contents, entry n at bit n |
| cfg_lut_g | input | 16 | G table contents, entry n at bit n |
| cfg_pick_f | input | 5 | F address variable selects |
| cfg_pick_g | input | 5 | G address variable selects |
| cfg_dsrc_x | input | 2 | Register X data select |
| cfg_dsrc_y | input | 2 | Register Y data select |
| cfg_osel_x | input | 2 | Output X select |
| cfg_osel_y | input | 2 | Output Y select |
| out_x | output | 1 | Cell output X |
| out_y | output | 1 | Cell output Y |

## Verification
The combinational core is tried in every mode with random table contents, random pick fields, random logic inputs and random register values. The register values are loaded beforehand through the F and G data paths. A wrong address bit, a wrong variable map or a swapped fifth-input choice therefore shows up as a mismatch against the bench's own model. In join mode the G pick field is randomized separately, so any use of it is caught. A loop with the pick fields fixed on the register selects shows that feedback reaches the address. Directed register patterns then separate a working enable from a stuck one. They also separate a clear that acts asynchronously in mid-cycle from one that waits for an edge, and the direct reset from the global one.

// File: rtl/lc_pkg.sv
`timescale 1ns/1ps
package lc_pkg;
  localparam int LC_ADDR_W = 4;
  localparam int LC_LUT_W  = 1 << LC_ADDR_W;
  localparam int LC_NLIN   = 5;
  localparam int LC_SEL_W  = 2;
  localparam int LC_PICK_W = 2 * LC_SEL_W + 1;
  localparam int LC_NTAB   = 2;

  typedef enum logic [1:0] {
    MODE_SPLIT = 2'd0,
    MODE_JOIN  = 2'd1,
    MODE_MUX   = 2'd2,
    MODE_ALT   = 2'd3
  } lc_mode_e;

  typedef struct packed {
    logic                hi_e;
    logic [LC_SEL_W-1:0] v2;
    logic [LC_SEL_W-1:0] v1;
  } lc_pick_t;

  // Variable pool lookup: two logic inputs or two register outputs
  function automatic logic pick_var(input logic [LC_SEL_W-1:0] sel,
                                    input logic [LC_NLIN-1:0] lin,
                                    input logic qx, input logic qy);
    case (sel)
      2'd0:    return lin[1];
      2'd1:    return lin[2];
      2'd2:    return qx;
      default: return qy;
    endcase
  endfunction

  // Four-way selector shared by register data and output muxes
  function automatic logic sel4(input logic [1:0] s, input logic a0,
                                input logic a1, input logic a2, input logic a3);
    case (s)
      2'd0:    return a0;
      2'd1:    return a1;
      2'd2:    return a2;
      default: return a3;
    endcase
  endfunction
endpackage

// File: rtl/lc_addr_mux.sv
`timescale 1ns/1ps
module lc_addr_mux
  import lc_pkg::*;
(
  input  logic [LC_NLIN-1:0]   lin,
  input  logic                 qx,
  input  logic                 qy,
  input  lc_pick_t             pick,
  input  logic                 split_mode,
  output logic [LC_ADDR_W-1:0] addr
);
  always_comb begin
    addr[0] = lin[0];
    addr[1] = pick_var(pick.v1, lin, qx, qy);
    addr[2] = pick_var(pick.v2, lin, qx, qy);
    addr[3] = (split_mode && pick.hi_e) ? lin[4] : lin[3];
  end
endmodule

// File: rtl/lc_fgen.sv
`timescale 1ns/1ps
module lc_fgen
  import lc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_any,
  input  lc_mode_e             mode,
  input  logic [LC_LUT_W-1:0]  lut_f,
  input  logic [LC_LUT_W-1:0]  lut_g,
  input  logic [LC_ADDR_W-1:0] addr_f,
  input  logic [LC_ADDR_W-1:0] addr_g,
  input  logic                 sel5,
  output logic                 res_f,
  output logic                 res_g
);
  logic raw_f, raw_g, merged, is_split;

  assign raw_f    = lut_f[addr_f];
  assign raw_g    = lut_g[addr_g];
  assign merged   = sel5 ? raw_g : raw_f;
  assign is_split = (mode == MODE_SPLIT) || (mode == MODE_ALT);

  always_comb begin
    if (is_split) begin
      res_f = raw_f;
      res_g = raw_g;
    end else begin
      res_f = merged;
      res_g = merged;
    end
  end

  AST_SHARED_RESULT: assert property (@(posedge clk) disable iff (rst_any)
    (mode == MODE_JOIN || mode == MODE_MUX) |-> (res_f == res_g))
    else $error("shared result differs"); // R3

  AST_SEL5_LOW_F: assert property (@(posedge clk) disable iff (rst_any)
    (mode == MODE_MUX && !sel5) |-> (res_g == lut_f[addr_f]))
    else $error("fifth input low did not pick F"); // R3
endmodule

// File: rtl/lc_regs.sv
`timescale 1ns/1ps
module lc_regs
  import lc_pkg::*;
(
  input  logic clk,
  input  logic ce,
  input  logic rst_dir,
  input  logic rst_glb,
  input  logic d_x,
  input  logic d_y,
  output logic q_x,
  output logic q_y
);
  logic rst_any;
  assign rst_any = rst_dir | rst_glb;

  always_ff @(posedge clk or posedge rst_any) begin
    if (rst_any) begin
      q_x <= 1'b0;
      q_y <= 1'b0;
    end else if (ce) begin
      q_x <= d_x;
      q_y <= d_y;
    end
  end

  AST_RST_CLEARS: assert property (@(posedge clk)
    rst_any |-> (q_x == 1'b0 && q_y == 1'b0))
    else $error("reset left a register set"); // R8

  AST_CE_HOLD: assert property (@(posedge clk) disable iff (rst_any)
    !ce |=> ($stable(q_x) && $stable(q_y)))
    else $error("register moved without enable"); // R7

  AST_CE_LOAD: assert property (@(posedge clk) disable iff (rst_any)
    ce |=> (q_x == $past(d_x) && q_y == $past(d_y)))
    else $error("register missed its load"); // R6
endmodule

// File: rtl/lc_cell.sv
`timescale 1ns/1ps
module lc_cell
  import lc_pkg::*;
(
  input  logic        clk,
  input  logic        ce,
  input  logic        rst_dir,
  input  logic        rst_glb,
  input  logic [4:0]  lin,
  input  logic        din,
  input  logic [1:0]  cfg_mode,
  input  logic [15:0] cfg_lut_f,
  input  logic [15:0] cfg_lut_g,
  input  logic [4:0]  cfg_pick_f,
  input  logic [4:0]  cfg_pick_g,
  input  logic [1:0]  cfg_dsrc_x,
  input  logic [1:0]  cfg_dsrc_y,
  input  logic [1:0]  cfg_osel_x,
  input  logic [1:0]  cfg_osel_y,
  output logic        out_x,
  output logic        out_y
);
  lc_mode_e             mode;
  lc_pick_t             pick_eff [LC_NTAB];
  logic [LC_ADDR_W-1:0] addr     [LC_NTAB];
  logic                 split_mode, res_f, res_g, q_x, q_y, d_x, d_y, rst_any;

  assign mode       = lc_mode_e'(cfg_mode);
  assign split_mode = (mode == MODE_SPLIT) || (mode == MODE_ALT);
  assign rst_any    = rst_dir | rst_glb;

  // Join mode forces one shared selection for both tables
  assign pick_eff[0] = lc_pick_t'(cfg_pick_f);
  assign pick_eff[1] = (mode == MODE_JOIN) ? lc_pick_t'(cfg_pick_f)
                                           : lc_pick_t'(cfg_pick_g);

  for (genvar k = 0; k < LC_NTAB; k++) begin : g_addr
    lc_addr_mux u_amux (
      .lin        (lin),
      .qx         (q_x),
      .qy         (q_y),
      .pick       (pick_eff[k]),
      .split_mode (split_mode),
      .addr       (addr[k])
    );
  end

  lc_fgen u_fgen (
    .clk     (clk),
    .rst_any (rst_any),
    .mode    (mode),
    .lut_f   (cfg_lut_f),
    .lut_g   (cfg_lut_g),
    .addr_f  (addr[0]),
    .addr_g  (addr[1]),
    .sel5    (lin[4]),
    .res_f   (res_f),
    .res_g   (res_g)
  );

  assign d_x = sel4(cfg_dsrc_x, din, res_f, res_g, din);
  assign d_y = sel4(cfg_dsrc_y, din, res_f, res_g, din);

  lc_regs u_regs (
    .clk     (clk),
    .ce      (ce),
    .rst_dir (rst_dir),
    .rst_glb (rst_glb),
    .d_x     (d_x),
    .d_y     (d_y),
    .q_x     (q_x),
    .q_y     (q_y)
  );

  assign out_x = sel4(cfg_osel_x, res_f, res_g, q_x, q_y);
  assign out_y = sel4(cfg_osel_y, res_f, res_g, q_x, q_y);

  AST_JOIN_SAME_ADDR: assert property (@(posedge clk) disable iff (rst_any)
    (mode == MODE_JOIN) |-> (addr[0] == addr[1]))
    else $error("join mode tables addressed apart"); // R2

  AST_OUT_REG_X: assert property (@(posedge clk) disable iff (rst_any)
    (cfg_osel_y == 2'd2) |-> (out_y == q_x))
    else $error("output did not show register X"); // R9
endmodule

// File: tb/lc_cell_bench.sv
`timescale 1ns/1ps
module lc_cell_bench;
  logic        clk = 1'b0;
  logic        ce, rst_dir, rst_glb, din;
  logic [4:0]  lin, cfg_pick_f, cfg_pick_g;
  logic [1:0]  cfg_mode, cfg_dsrc_x, cfg_dsrc_y, cfg_osel_x, cfg_osel_y;
  logic [15:0] cfg_lut_f, cfg_lut_g;
  logic        out_x, out_y;
  logic        exp_qx, exp_qy;
  int          total = 0;
  int          bad   = 0;

  always #2.5 clk = ~clk;

  lc_cell u_lc_cell (
    .clk(clk), .ce(ce), .rst_dir(rst_dir), .rst_glb(rst_glb), .lin(lin),
    .din(din), .cfg_mode(cfg_mode), .cfg_lut_f(cfg_lut_f),
    .cfg_lut_g(cfg_lut_g), .cfg_pick_f(cfg_pick_f), .cfg_pick_g(cfg_pick_g),
    .cfg_dsrc_x(cfg_dsrc_x), .cfg_dsrc_y(cfg_dsrc_y),
    .cfg_osel_x(cfg_osel_x), .cfg_osel_y(cfg_osel_y),
    .out_x(out_x), .out_y(out_y)
  );

  // Pool positions: 0..4 logic inputs, 5 register X, 6 register Y
  function automatic int pool_index(input logic [1:0] s);
    int map [4] = '{1, 2, 5, 6};
    return map[s];
  endfunction

  function automatic logic [1:0] model(input logic [1:0] md,
      input logic [15:0] tf, input logic [15:0] tg, input logic [4:0] pf,
      input logic [4:0] pg, input logic [4:0] li, input logic qx, input logic qy);
    logic [6:0] pool;
    logic [4:0] pg_use;
    logic [3:0] af, ag;
    logic       split, vf, vg;
    pool   = {qy, qx, li};
    split  = (md == 2'd0) || (md == 2'd3);
    pg_use = (md == 2'd1) ? pf : pg;
    af = {(split && pf[4]) ? pool[4] : pool[3],
          pool[pool_index(pf[3:2])], pool[pool_index(pf[1:0])], pool[0]};
    ag = {(split && pg_use[4]) ? pool[4] : pool[3],
          pool[pool_index(pg_use[3:2])], pool[pool_index(pg_use[1:0])], pool[0]};
    vf = tf[af];
    vg = tg[ag];
    if (split) return {vg, vf};
    return pool[4] ? {vg, vg} : {vf, vf};
  endfunction

  task automatic chk(input string req, input logic act, input logic expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, expv);
    end
  endtask

  // Load registers through the table paths (R6: F to X, G to Y)
  task automatic load_q(input logic bx, input logic by);
    @(negedge clk);
    cfg_mode = 2'd0; cfg_lut_f = {16{bx}}; cfg_lut_g = {16{by}};
    cfg_dsrc_x = 2'd1; cfg_dsrc_y = 2'd2; ce = 1'b1;
    @(posedge clk); #1;
    exp_qx = bx; exp_qy = by;
    @(negedge clk); ce = 1'b0;
  endtask

  task automatic check_q(input string req);
    cfg_osel_x = 2'd2; cfg_osel_y = 2'd3; #1;
    chk(req, out_x, exp_qx);
    chk(req, out_y, exp_qy);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check_q("R8 reset state");
    rst_glb = 1'b0;
  endtask

  task automatic t_random(input logic [1:0] md, input string req, input int n);
    logic [1:0] e;
    for (int i = 0; i < n; i++) begin
      load_q(1'($urandom), 1'($urandom));
      cfg_mode = md;
      cfg_lut_f = 16'($urandom); cfg_lut_g = 16'($urandom);
      cfg_pick_f = 5'($urandom); cfg_pick_g = 5'($urandom);
      cfg_osel_x = 2'd0; cfg_osel_y = 2'd1;
      lin = 5'($urandom); #1;
      e = model(md, cfg_lut_f, cfg_lut_g, cfg_pick_f, cfg_pick_g, lin, exp_qx, exp_qy);
      chk({req, " F"}, out_x, e[0]);
      chk({req, " G"}, out_y, e[1]);
      lin = ~lin; #1; // R10: same-cycle response
      e = model(md, cfg_lut_f, cfg_lut_g, cfg_pick_f, cfg_pick_g, lin, exp_qx, exp_qy);
      chk("R10 comb F", out_x, e[0]);
      chk("R10 comb G", out_y, e[1]);
    end
  endtask

  // R4: address bits 1,2 from register X,Y
  task automatic t_qsub;
    logic [1:0] e;
    for (int i = 0; i < 4; i++) begin
      load_q(1'(i), 1'(i >> 1));
      cfg_mode = 2'd0;
      cfg_lut_f = 16'($urandom); cfg_lut_g = 16'($urandom);
      cfg_pick_f = 5'b0_11_10; cfg_pick_g = 5'b1_10_11;
      cfg_osel_x = 2'd0; cfg_osel_y = 2'd1;
      lin = 5'($urandom); #1;
      e = model(2'd0, cfg_lut_f, cfg_lut_g, cfg_pick_f, cfg_pick_g, lin, exp_qx, exp_qy);
      chk("R4 reg feedback F", out_x, e[0]);
      chk("R4 reg feedback G", out_y, e[1]);
    end
  endtask

  task automatic t_dsrc;
    load_q(1'b0, 1'b0);
    din = 1'b1; cfg_dsrc_x = 2'd0; cfg_dsrc_y = 2'd3; ce = 1'b1;
    @(posedge clk); #1; exp_qx = 1'b1; exp_qy = 1'b1;
    @(negedge clk); ce = 1'b0;
    check_q("R6 din source");
  endtask

  task automatic t_ce;
    load_q(1'b1, 1'b0);
    din = 1'b0; cfg_dsrc_x = 2'd0; cfg_dsrc_y = 2'd0; cfg_lut_f = 16'hFFFF; ce = 1'b0;
    @(posedge clk); @(negedge clk);
    check_q("R7 enable low hold");
  endtask

  task automatic t_osel;
    load_q(1'b1, 1'b0);
    cfg_osel_x = 2'd3; cfg_osel_y = 2'd2; #1;
    chk("R9 out_x shows Y", out_x, 1'b0);
    chk("R9 out_y shows X", out_y, 1'b1);
    cfg_mode = 2'd0; cfg_pick_f = 5'd0; cfg_pick_g = 5'd0;
    cfg_lut_f = 16'h0000; cfg_lut_g = 16'hFFFF;
    cfg_osel_x = 2'd1; cfg_osel_y = 2'd0; #1;
    chk("R9 out_x shows G", out_x, 1'b1);
    chk("R9 out_y shows F", out_y, 1'b0);
  endtask

  task automatic t_async(input logic use_glb, input string req);
    load_q(1'b1, 1'b1);
    din = 1'b1; cfg_dsrc_x = 2'd0; cfg_dsrc_y = 2'd0; ce = 1'b1;
    if (use_glb) rst_glb = 1'b1; else rst_dir = 1'b1;
    exp_qx = 1'b0; exp_qy = 1'b0;
    check_q({req, " mid-cycle clear"});
    @(posedge clk); @(negedge clk);
    check_q({req, " held across edge"});
    rst_dir = 1'b0; rst_glb = 1'b0; ce = 1'b0;
  endtask

  initial begin
    ce = 1'b0; rst_dir = 1'b0; rst_glb = 1'b1; din = 1'b0; lin = 5'd0;
    cfg_mode = 2'd0; cfg_lut_f = 16'd0; cfg_lut_g = 16'd0;
    cfg_pick_f = 5'd0; cfg_pick_g = 5'd0; cfg_dsrc_x = 2'd0; cfg_dsrc_y = 2'd0;
    cfg_osel_x = 2'd2; cfg_osel_y = 2'd3; exp_qx = 1'b0; exp_qy = 1'b0;
    repeat (2) @(posedge clk);
    t_reset();
    t_random(2'd0, "R1 split", 24);
    t_random(2'd1, "R2 join", 24);
    t_random(2'd2, "R3 mux", 24);
    t_random(2'd3, "R5 mode code 3", 12);
    t_qsub();
    t_dsrc();
    t_ce();
    t_osel();
    t_async(1'b0, "R8 direct");
    t_async(1'b1, "R8 global");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule